// File: doc/BRIEF.md
# Transmit End-of-Message Controller

This block decides what a bit-oriented (HDLC-style) or byte-synchronous transmitter sends next, and it owns the end-of-message latch. When a message is running and the transmit buffer runs dry, the latch picks the outcome. If the latch is clear, the frame check sequence is appended automatically. In HDLC mode with abort-on-underrun selected, an abort and then a flag are sent instead. If the latch is already set, the line simply idles with fill characters. The host can clear the latch, start the transmit CRC generator, or command an abort at any time.

The serializer asks for its next source through `load_req`. It reports each shifted bit on `bit_tick` and the end of the CRC on `crc_done`. The block answers on `src_sel`, with a one-cycle buffer-flush pulse and a one-cycle CRC-initialise pulse. No data stream passes through the block, so every pin is plain control or status with no back-pressure. All outputs are registered and change on the clock edge after the input that causes them.

Top module: `tx_eom_ctrl`

## Requirements
- R1: After reset, `src_sel` is idle (0), `eom_latch` is 1, and `flush` and `crc_init` are 0.
- R2: A command write with `cmd_crc` = 2'b10 gives exactly one `crc_init` pulse, in the cycle after the write. Other `cmd_crc` codes give none, and reset never gives one.
- R3: A command write with `cmd_crc` = 2'b11 clears `eom_latch` on the next edge when `tx_en` is 1. The write is ignored while `tx_en` is 0.
- R4: If `load_req` arrives while sending data (`src_sel` = 1) with `buf_empty` = 1 and the latch clear, and abort-on-underrun does not apply, then `src_sel` becomes CRC (2). `eom_latch` becomes 1 on that same edge.
- R5: While sending CRC, `crc_done` moves `src_sel` to fill (4). Fill holds until a `load_req` with `buf_empty` = 0 moves it to data (1).
- R6: If `sdlc_mode` = 1 and `abort_on_underrun` = 1, an underrun with the latch clear moves `src_sel` to abort (3) and sets the latch. After exactly 8 `bit_tick` pulses it moves to fill (4).
- R7: An underrun while `eom_latch` = 1 moves `src_sel` to fill (4) and never to CRC.
- R8: A command write with `cmd_op` = 3'b011 pulses `flush` for one cycle and sets `eom_latch`. If `tx_en` = 1, it also moves `src_sel` to abort (3) for 8 bit ticks.
- R9: While `tx_en` = 0, `src_sel` is idle (0) from the next edge on. Enabling the transmitter moves it to fill (4).
- R10: `abort_on_underrun` has no effect when `sdlc_mode` = 0: an underrun with the latch clear still selects CRC (2).
- R11: `load_req` is ignored while `src_sel` is CRC (2) or abort (3).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low channel reset |
| tx_en | input | 1 | Transmitter enable |
| buf_empty | input | 1 | Transmit buffer holds no character |
| load_req | input | 1 | Serializer requests its next source |
| bit_tick | input | 1 | Serializer shifted one bit |
| crc_done | input | 1 | Last CRC bit has been shifted |
| sdlc_mode | input | 1 | 1 = bit-oriented framing, 0 = byte sync |
| abort_on_underrun | input | 1 | Send an abort instead of CRC on underrun |
| cmd_wr | input | 1 | Host command strobe |
| cmd_crc | input | 2 | CRC/latch command field |
| cmd_op | input | 3 | General command field (3'b011 = send abort) |
| src_sel | output | 3 | Next source: 0 idle, 1 data, 2 CRC, 3 abort ones, 4 fill |
| flush | output | 1 | One-cycle transmit buffer flush |
| crc_init | output | 1 | One-cycle CRC generator initialise |
| eom_latch | output | 1 | Underrun/end-of-message latch state |

## Verification
A latch stuck set shows on the next underrun: `src_sel` goes to fill where CRC or abort was expected. A latch that wrongly clears while disabled shows at once on `eom_latch`. A miscounted abort shows as fill arriving one tick early or late. A state that wrongly reacts to `load_req` during CRC shows on `src_sel` on the very next edge. Each of these faults is visible at most one clock after the stimulus, so the bench checks every step on the edge right after it.

// File: rtl/tx_eom_pkg.sv
package tx_eom_pkg;
  typedef enum logic [2:0] {
    SRC_IDLE  = 3'd0,
    SRC_DATA  = 3'd1,
    SRC_CRC   = 3'd2,
    SRC_ABORT = 3'd3,
    SRC_FILL  = 3'd4
  } src_e;

  localparam logic [1:0] CRC_CMD_INIT  = 2'b10;
  localparam logic [1:0] CRC_CMD_CLEAR = 2'b11;
  localparam logic [2:0] OP_CMD_ABORT  = 3'b011;
endpackage

// File: rtl/eom_cmd_decode.sv
module eom_cmd_decode
  import tx_eom_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cmd_wr,
  input  logic [1:0] cmd_crc,
  input  logic [2:0] cmd_op,
  output logic       clr_req,
  output logic       abort_req,
  output logic       crc_init
);
  assign clr_req   = cmd_wr && (cmd_crc == CRC_CMD_CLEAR);
  assign abort_req = cmd_wr && (cmd_op == OP_CMD_ABORT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) crc_init <= 1'b0;
    else        crc_init <= cmd_wr && (cmd_crc == CRC_CMD_INIT);
  end

  // R2: a CRC init pulse always traces back to an init write one cycle earlier
  p_init_from_cmd_r2: assert property (@(posedge clk) disable iff (!rst_n)
    crc_init |-> $past(cmd_wr && cmd_crc == CRC_CMD_INIT));
endmodule

// File: rtl/eom_latch.sv
module eom_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic tx_en,
  input  logic set_req,
  input  logic clr_req,
  output logic latch_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                latch_q <= 1'b1;
    else if (set_req)          latch_q <= 1'b1;
    else if (clr_req && tx_en) latch_q <= 1'b0;
  end

  // R3: the latch never clears while the transmitter was disabled
  p_no_clear_disabled_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(latch_q) |-> $past(tx_en));
endmodule

// File: rtl/eom_abort_timer.sv
module eom_abort_timer #(
  parameter int ABORT_LEN = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic active,
  input  logic tick,
  output logic done
);
  localparam int CW = $clog2(ABORT_LEN + 1);
  localparam logic [CW-1:0] LAST = CW'(ABORT_LEN - 1);

  logic [CW-1:0] cnt;

  assign done = active && tick && (cnt == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt <= '0;
    else if (start || done)  cnt <= '0;
    else if (active && tick) cnt <= cnt + 1'b1;
  end

  // R6: the ones counter stays below the abort length
  p_cnt_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
    cnt < CW'(ABORT_LEN));
endmodule

// File: rtl/tx_eom_ctrl.sv
module tx_eom_ctrl
  import tx_eom_pkg::*;
#(
  parameter int ABORT_LEN = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tx_en,
  input  logic       buf_empty,
  input  logic       load_req,
  input  logic       bit_tick,
  input  logic       crc_done,
  input  logic       sdlc_mode,
  input  logic       abort_on_underrun,
  input  logic       cmd_wr,
  input  logic [1:0] cmd_crc,
  input  logic [2:0] cmd_op,
  output logic [2:0] src_sel,
  output logic       flush,
  output logic       crc_init,
  output logic       eom_latch
);
  src_e state, state_nxt;
  logic clr_req, abort_req, set_req, abort_done;
  logic underrun, go_crc, go_abort;

  eom_cmd_decode u_dec (
    .clk(clk), .rst_n(rst_n), .cmd_wr(cmd_wr), .cmd_crc(cmd_crc),
    .cmd_op(cmd_op), .clr_req(clr_req), .abort_req(abort_req),
    .crc_init(crc_init)
  );

  eom_latch u_latch (
    .clk(clk), .rst_n(rst_n), .tx_en(tx_en), .set_req(set_req),
    .clr_req(clr_req), .latch_q(eom_latch)
  );

  eom_abort_timer #(.ABORT_LEN(ABORT_LEN)) u_tmr (
    .clk(clk), .rst_n(rst_n), .start(go_abort),
    .active(state == SRC_ABORT), .tick(bit_tick), .done(abort_done)
  );

  assign underrun = tx_en && !abort_req && (state == SRC_DATA) && load_req && buf_empty;
  assign go_crc   = underrun && !eom_latch && !(sdlc_mode && abort_on_underrun);
  assign go_abort = tx_en && (abort_req || (underrun && !eom_latch && sdlc_mode && abort_on_underrun));
  assign set_req  = go_crc || go_abort || abort_req;

  always_comb begin
    state_nxt = state;
    if (!tx_en)           state_nxt = SRC_IDLE;
    else if (go_abort)    state_nxt = SRC_ABORT;
    else if (go_crc)      state_nxt = SRC_CRC;
    else begin
      unique case (state)
        SRC_IDLE:  state_nxt = SRC_FILL;
        SRC_DATA:  if (load_req) state_nxt = buf_empty ? SRC_FILL : SRC_DATA;
        SRC_FILL:  if (load_req && !buf_empty) state_nxt = SRC_DATA;
        SRC_CRC:   if (crc_done) state_nxt = SRC_FILL;
        SRC_ABORT: if (abort_done) state_nxt = SRC_FILL;
        default:   state_nxt = SRC_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= SRC_IDLE;
      flush <= 1'b0;
    end else begin
      state <= state_nxt;
      flush <= abort_req;
    end
  end

  assign src_sel = state;

  // R4: the latch is set on the edge that starts CRC transmission
  p_crc_sets_latch_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (state == SRC_CRC && $past(state) != SRC_CRC) |-> eom_latch);
  // R9: a disabled transmitter idles from the next edge
  p_idle_when_off_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_en |=> state == SRC_IDLE);
  // R8: a flush is always accompanied by a set latch
  p_flush_sets_latch_r8: assert property (@(posedge clk) disable iff (!rst_n)
    flush |-> eom_latch);
endmodule

// File: tb/tb_tx_eom_ctrl.sv
module tb_tx_eom_ctrl;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tx_en = 0, buf_empty = 1, load_req = 0, bit_tick = 0, crc_done = 0;
  logic sdlc_mode = 0, abort_on_underrun = 0, cmd_wr = 0;
  logic [1:0] cmd_crc = 0;
  logic [2:0] cmd_op = 0;
  logic [2:0] src_sel;
  logic flush, crc_init, eom_latch;
  int total = 0, bad = 0;

  always #10 clk = ~clk;

  tx_eom_ctrl dut (
    .clk(clk), .rst_n(rst_n), .tx_en(tx_en), .buf_empty(buf_empty),
    .load_req(load_req), .bit_tick(bit_tick), .crc_done(crc_done),
    .sdlc_mode(sdlc_mode), .abort_on_underrun(abort_on_underrun),
    .cmd_wr(cmd_wr), .cmd_crc(cmd_crc), .cmd_op(cmd_op),
    .src_sel(src_sel), .flush(flush), .crc_init(crc_init), .eom_latch(eom_latch)
  );

  task automatic chk(string req, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cyc();
    @(posedge clk); #2;
  endtask

  task automatic cmd(logic [1:0] c, logic [2:0] o);
    cmd_wr = 1; cmd_crc = c; cmd_op = o; cyc();
    cmd_wr = 0; cmd_crc = 0; cmd_op = 0;
  endtask

  task automatic req(logic empty);
    buf_empty = empty; load_req = 1; cyc(); load_req = 0;
  endtask

  task automatic t_reset();
    chk("R1 src", src_sel, 0); chk("R1 latch", eom_latch, 1);
    chk("R1 flush", flush, 0); chk("R1 crc_init", crc_init, 0);
  endtask

  task automatic t_enable();
    tx_en = 1; cyc(); chk("R9 enable fill", src_sel, 4);
  endtask

  task automatic t_crc_init();
    cmd(2'b10, 3'b000); chk("R2 pulse", crc_init, 1);
    cyc(); chk("R2 one cycle", crc_init, 0);
    cmd(2'b00, 3'b000); chk("R2 null code", crc_init, 0);
  endtask

  task automatic t_clear();
    tx_en = 0; cyc();
    cmd(2'b11, 3'b000); chk("R3 ignored disabled", eom_latch, 1);
    chk("R9 idle", src_sel, 0);
    tx_en = 1; cyc();
    cmd(2'b11, 3'b000); chk("R3 cleared", eom_latch, 0);
  endtask

  task automatic t_crc_append();
    req(0); chk("R5 data", src_sel, 1);
    req(1); chk("R4 crc", src_sel, 2); chk("R4 latch", eom_latch, 1);
    req(0); chk("R11 ignore in crc", src_sel, 2);
    crc_done = 1; cyc(); crc_done = 0; chk("R5 fill", src_sel, 4);
    req(1); chk("R5 fill holds", src_sel, 4);
  endtask

  task automatic t_latched();
    req(0); chk("R7 data", src_sel, 1);
    req(1); chk("R7 no crc", src_sel, 4); chk("R7 latch", eom_latch, 1);
  endtask

  task automatic ticks(int n);
    for (int i = 0; i < n; i++) begin bit_tick = 1; cyc(); bit_tick = 0; end
  endtask

  task automatic t_abort_ur();
    sdlc_mode = 1; abort_on_underrun = 1;
    cmd(2'b11, 3'b000);
    req(0); req(1);
    chk("R6 abort", src_sel, 3); chk("R6 latch", eom_latch, 1);
    req(0); chk("R11 ignore in abort", src_sel, 3);
    ticks(7); chk("R6 still abort", src_sel, 3);
    ticks(1); chk("R6 fill after 8", src_sel, 4);
  endtask

  task automatic t_nonsdlc();
    sdlc_mode = 0; abort_on_underrun = 1;
    cmd(2'b11, 3'b000);
    req(0); req(1); chk("R10 crc", src_sel, 2);
    crc_done = 1; cyc(); crc_done = 0;
  endtask

  task automatic t_send_abort();
    cmd(2'b11, 3'b000); req(0);
    cmd(2'b00, 3'b011);
    chk("R8 abort", src_sel, 3); chk("R8 flush", flush, 1); chk("R8 latch", eom_latch, 1);
    cyc(); chk("R8 flush once", flush, 0);
    ticks(8); chk("R8 fill", src_sel, 4);
  endtask

  task automatic t_disable();
    tx_en = 0; cyc(); chk("R9 idle", src_sel, 0);
  endtask

  initial begin
    for (int i = 0; i < 20000; i++) @(posedge clk);
    bad++;
    $display("FAIL watchdog actual=1 expected=0");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #25; t_reset();
    @(negedge clk); rst_n = 1; cyc();
    chk("R2 no pulse from reset", crc_init, 0);
    t_enable(); t_crc_init(); t_clear(); t_crc_append(); t_latched();
    t_abort_ur(); t_nonsdlc(); t_send_abort(); t_disable();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule